// File: doc/BRIEF.md
# Compressed Instruction Pair Expander

This block sits between instruction fetch and decode in a small 32-bit processor. Fetched words arrive over a valid/ready handshake. A word whose top bit is clear is a full-size instruction and goes to decode unchanged. A word whose top bit is set carries two 15-bit short instructions. The block rewrites each short instruction into the full-size encoding that decode already understands. It issues the upper half first and the lower half second.

The fetched word stays on the input until its second half has been taken downstream, so the block stores only which half is current. A flush input throws away a partly issued pair. A full-size instruction that uses the simulator-call opcode is flagged illegal when the block is built for hardware.

Full-size layout used throughout: bit 31 = 0, [30:27] destination register, [26:22] opcode, [21:19] condition (000 = always), [18] operand selector. When the selector is 0, [17:0] is an 18-bit immediate. When it is 1, [17:14] is the B register and [13:0] is a 14-bit immediate. The load-immediate form is the exception: [26:23] = 1100 and [22:0] is a 23-bit immediate. A short half h[14:0] holds destination h[14:11], short opcode h[10:8], selector h[7] and operand field h[6:0]. Within that field, B register = h[6:3] and small offset = h[2:0].

Top module: `cpx_pair_expander`

## Requirements
- R1: A word with bit 31 = 0 appears on outWord bit for bit. outValid follows inValid, and inReady equals outReady while flush is low.
- R2: A word with bit 31 = 1 is issued as two outputs: the expansion of bits [30:16] first, then the expansion of bits [14:0]. Bit 15 has no effect. inReady is high only in the cycle in which the second output is accepted. After reset the first half is issued first.
- R3: Short opcodes 000, 001, 010 and 011 become full opcodes 00000 (SUB), 00001 (AND), 00010 (ADD) and 10000 (CMP), with condition 000. With selector 0, the 7-bit field is sign-extended into the 18-bit immediate. With selector 1, B register = h[6:3] and the 14-bit immediate is h[2:0] sign-extended.
- R4: Short opcodes 100 and 101 become load-word (10010) and store-word (10011), with condition 000 and full selector 1. With short selector 0, the B register is 13 (stack pointer) and the 14-bit immediate is the 7-bit field sign-extended (-64..63). With short selector 1, B register = h[6:3] and the offset is h[2:0] sign-extended.
- R5: Short opcode 110 becomes load-immediate: [26:23] = 1100, and [22:0] is the sign extension of the 8-bit value {h[7], h[6:0]} (-128..127).
- R6: Short opcode 111 becomes MOV (01101) with condition 000 and full selector 1. B register = h[6:3], and the 14-bit immediate is the sign extension of the 4-bit value {h[7], h[2:0]} (-8..7).
- R7: With SIM_MODE = 0, outIllegal is high exactly when a full-size word with opcode 11110 is presented. Opcode 11111 (no-op) never raises it, whatever its immediate, and expanded halves never raise it.
- R8: While flush is high, outValid is low. A pair whose first half was already accepted is consumed (inReady high) and its second half is never issued. The next pair starts at its first half.
- R9: While outValid is high and outReady low, outWord holds its value for as long as the input word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the current output and any pending second half |
| inValid | input | 1 | Fetched word present |
| inReady | output | 1 | Fetched word consumed this cycle |
| inWord | input | 32 | Fetched instruction word |
| outValid | output | 1 | Expanded instruction present |
| outReady | input | 1 | Decode accepts the instruction |
| outWord | output | 32 | Full-size instruction to decode |
| outIllegal | output | 1 | Instruction is illegal in this build |

## Verification
Some rules are checked by assertions on every cycle. These cover the handshake rules: a pair is never acknowledged on its first half, an accepted first half always moves the block to the second half, and a flush both silences the output and clears the pending half. The same assertions check that plain words pass unchanged and that the illegal flag rises only for the simulator-call opcode. Other properties are shown only by the bench's scenarios: the field-by-field correctness of each expansion, the extreme immediates of each short form, the stack-pointer default, the ignored spare bit, and stability under irregular back-pressure.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = 15;
  localparam int REG_W    = 4;
  localparam int OP_W     = 5;
  localparam int COND_W   = 3;
  localparam int FIELD_W  = 7;
  localparam int IMM18_W  = 18;
  localparam int IMM14_W  = 14;
  localparam int IMM23_W  = 23;
  localparam int FIRST_LSB  = 16;
  localparam int SECOND_LSB = 0;

  localparam logic [REG_W-1:0]  SP_REG    = 4'd13;
  localparam logic [COND_W-1:0] COND_ALL  = 3'b000;
  localparam logic [OP_W-1:0]   OPC_SUB   = 5'b00000;
  localparam logic [OP_W-1:0]   OPC_AND   = 5'b00001;
  localparam logic [OP_W-1:0]   OPC_ADD   = 5'b00010;
  localparam logic [OP_W-1:0]   OPC_CMP   = 5'b10000;
  localparam logic [OP_W-1:0]   OPC_LW    = 5'b10010;
  localparam logic [OP_W-1:0]   OPC_SW    = 5'b10011;
  localparam logic [OP_W-1:0]   OPC_MOV   = 5'b01101;
  localparam logic [OP_W-2:0]   OPC_LDI4  = 4'b1100;
  localparam logic [OP_W-1:0]   OPC_SIM   = 5'b11110;

  typedef enum logic [2:0] {
    SH_SUB = 3'd0, SH_AND = 3'd1, SH_ADD = 3'd2, SH_CMP = 3'd3,
    SH_LW  = 3'd4, SH_SW  = 3'd5, SH_LDI = 3'd6, SH_MOV = 3'd7
  } shortOp_e;

  typedef struct packed {
    logic selSecond;
    logic passThrough;
  } cpxStrobe_t;
endpackage

// File: rtl/cpx_half_expand.sv
module cpx_half_expand
  import cpx_pkg::*;
(
  input  logic [HALF_W-1:0] halfWord,
  output logic [WORD_W-1:0] fullWord
);
  logic [REG_W-1:0]   dstReg;
  logic [REG_W-1:0]   bReg;
  logic               selBit;
  logic [FIELD_W-1:0] field;
  shortOp_e           shortOp;
  logic [IMM18_W-1:0] imm18Wide;
  logic [IMM14_W-1:0] imm14Wide;
  logic [IMM14_W-1:0] imm14Tiny;
  logic [IMM14_W-1:0] imm14Mov;
  logic [IMM23_W-1:0] imm23Ldi;
  logic [OP_W-1:0]    aluOpc;

  always_comb begin
    dstReg    = halfWord[14:11];
    shortOp   = shortOp_e'(halfWord[10:8]);
    selBit    = halfWord[7];
    field     = halfWord[FIELD_W-1:0];
    bReg      = field[6:3];
    imm18Wide = {{(IMM18_W-FIELD_W){field[6]}}, field};
    imm14Wide = {{(IMM14_W-FIELD_W){field[6]}}, field};
    imm14Tiny = {{(IMM14_W-3){field[2]}}, field[2:0]};
    imm14Mov  = {{(IMM14_W-4){selBit}}, selBit, field[2:0]};
    imm23Ldi  = {{(IMM23_W-8){selBit}}, selBit, field};
  end

  always_comb begin
    unique case (shortOp)
      SH_SUB:  aluOpc = OPC_SUB;
      SH_AND:  aluOpc = OPC_AND;
      SH_ADD:  aluOpc = OPC_ADD;
      SH_CMP:  aluOpc = OPC_CMP;
      SH_LW:   aluOpc = OPC_LW;
      SH_SW:   aluOpc = OPC_SW;
      SH_MOV:  aluOpc = OPC_MOV;
      default: aluOpc = OPC_SUB;
    endcase
  end

  always_comb begin
    unique case (shortOp)
      SH_LDI:
        fullWord = {1'b0, dstReg, OPC_LDI4, imm23Ldi};
      SH_MOV:
        fullWord = {1'b0, dstReg, aluOpc, COND_ALL, 1'b1, bReg, imm14Mov};
      SH_LW, SH_SW:
        fullWord = selBit ? {1'b0, dstReg, aluOpc, COND_ALL, 1'b1, bReg, imm14Tiny}
                          : {1'b0, dstReg, aluOpc, COND_ALL, 1'b1, SP_REG, imm14Wide};
      default:
        fullWord = selBit ? {1'b0, dstReg, aluOpc, COND_ALL, 1'b1, bReg, imm14Tiny}
                          : {1'b0, dstReg, aluOpc, COND_ALL, 1'b0, imm18Wide};
    endcase
  end
endmodule

// File: rtl/cpx_datapath.sv
module cpx_datapath
  import cpx_pkg::*;
#(
  parameter bit SIM_MODE = 1'b0
)(
  input  logic [WORD_W-1:0] inWord,
  input  cpxStrobe_t        strobe,
  output logic              isPair,
  output logic [WORD_W-1:0] outWord,
  output logic              isIllegal
);
  logic [WORD_W-1:0] expanded [2];

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam int LSB = (g == 0) ? FIRST_LSB : SECOND_LSB;
    cpx_half_expand u_half (
      .halfWord (inWord[LSB +: HALF_W]),
      .fullWord (expanded[g])
    );
  end

  always_comb begin
    isPair = inWord[WORD_W-1];
    if (strobe.passThrough) outWord = inWord;
    else if (strobe.selSecond) outWord = expanded[1];
    else outWord = expanded[0];
    isIllegal = !SIM_MODE && !isPair && (inWord[26:22] == OPC_SIM);
  end
endmodule

// File: rtl/cpx_control.sv
module cpx_control
  import cpx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       inValid,
  input  logic       isPair,
  input  logic       outReady,
  output logic       outValid,
  output logic       inReady,
  output cpxStrobe_t strobe
);
  logic secondPhase;
  logic fire;

  always_comb begin
    outValid = inValid && !flush;
    fire     = outValid && outReady;
    if (flush)       inReady = secondPhase;
    else if (isPair) inReady = fire && secondPhase;
    else             inReady = outReady;
    strobe.selSecond   = secondPhase;
    strobe.passThrough = !isPair;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               secondPhase <= 1'b0;
    else if (flush)          secondPhase <= 1'b0;
    else if (fire && isPair) secondPhase <= !secondPhase;
  end

  AST_FIRST_NOT_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    (isPair && !secondPhase && !flush) |-> !inReady); // R2
  AST_ADVANCE_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (fire && isPair && !secondPhase) |=> secondPhase); // R2
  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !outValid); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !secondPhase); // R8
endmodule

// File: rtl/cpx_pair_expander.sv
module cpx_pair_expander
  import cpx_pkg::*;
#(
  parameter bit SIM_MODE = 1'b0
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flush,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inWord,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outWord,
  output logic        outIllegal
);
  cpxStrobe_t strobe;
  logic       isPair;

  cpx_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .inValid  (inValid),
    .isPair   (isPair),
    .outReady (outReady),
    .outValid (outValid),
    .inReady  (inReady),
    .strobe   (strobe)
  );

  cpx_datapath #(.SIM_MODE(SIM_MODE)) u_datapath (
    .inWord    (inWord),
    .strobe    (strobe),
    .isPair    (isPair),
    .outWord   (outWord),
    .isIllegal (outIllegal)
  );

  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inWord[31]) |-> (outWord == inWord)); // R1
  AST_ILLEGAL_SIM: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> (!inWord[31] && inWord[26:22] == 5'b11110)); // R7
endmodule

// File: tb/test_cpx_pair_expander.sv
module test_cpx_pair_expander;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [31:0] inWord = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [31:0] outWord;
  logic outIllegal;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpx_pair_expander i_cpx_pair_expander (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .outValid(outValid), .outReady(outReady),
    .outWord(outWord), .outIllegal(outIllegal)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [14:0] mkHalf(input int dst, input int op, input int sel, input int fld);
    logic [14:0] h;
    h = 15'((dst << 11) | (op << 8) | (sel << 7) | (fld & 'h7F));
    return h;
  endfunction

  // Behavioural encoder model built from the requirements (R3..R6)
  function automatic logic [31:0] refHalf(input logic [14:0] h);
    int dst, cop, sel, fld, s7, s3, s4, s8, breg, opc;
    logic [31:0] w;
    dst = int'(h[14:11]); cop = int'(h[10:8]); sel = int'(h[7]); fld = int'(h[6:0]);
    s7 = (fld >= 64) ? fld - 128 : fld;
    s3 = ((fld & 7) >= 4) ? (fld & 7) - 8 : (fld & 7);
    breg = fld >> 3;
    w = 32'(dst) << 27;
    case (cop)
      0, 1, 2, 3: begin
        opc = (cop == 3) ? 16 : cop;
        w |= 32'(opc) << 22;
        if (sel != 0) w |= (32'd1 << 18) | (32'(breg) << 14) | (32'(s3) & 32'h3FFF);
        else          w |= 32'(s7) & 32'h3FFFF;
      end
      4, 5: begin
        opc = 18 + cop - 4;
        w |= (32'(opc) << 22) | (32'd1 << 18);
        if (sel != 0) w |= (32'(breg) << 14) | (32'(s3) & 32'h3FFF);
        else          w |= (32'd13 << 14) | (32'(s7) & 32'h3FFF);
      end
      6: begin
        s8 = (sel != 0) ? fld - 128 : fld;
        w |= (32'd24 << 22) | (32'(s8) & 32'h7FFFFF);
      end
      default: begin
        s4 = (sel != 0) ? (fld & 7) - 8 : (fld & 7);
        w |= (32'd13 << 22) | (32'd1 << 18) | (32'(breg) << 14) | (32'(s4) & 32'h3FFF);
      end
    endcase
    return w;
  endfunction

  task automatic runWord(input logic [31:0] w, input string req, input bit cutAfterFirst);
    logic [31:0] expQ[$];
    int idx;
    bit done;
    bit ill;
    bit doFlush;
    expQ = {};
    if (w[31]) begin
      expQ.push_back(refHalf(w[30:16]));
      expQ.push_back(refHalf(w[14:0]));
    end else begin
      expQ.push_back(w);
    end
    ill = !w[31] && (w[26:22] == 5'b11110);
    idx = 0;
    done = 0;
    while (!done) begin
      @(negedge clk);
      inValid = 1'b1;
      inWord = w;
      doFlush = cutAfterFirst && (idx == 1);
      flush = doFlush;
      outReady = (cyc % 3) != 1;
      #1;
      if (doFlush) begin
        chk(outValid == 1'b0, "R8 flush valid", {31'b0, outValid}, 32'd0);
        chk(inReady == 1'b1, "R8 flush consume", {31'b0, inReady}, 32'd1);
        done = 1;
      end else begin
        chk(outValid == 1'b1, {req, " valid"}, {31'b0, outValid}, 32'd1);
        chk(outWord == expQ[idx], outReady ? req : {req, " R9 stall"}, outWord, expQ[idx]);
        chk(outIllegal == ill, "R7 illegal", {31'b0, outIllegal}, {31'b0, ill});
        chk(inReady == (outReady && (idx == expQ.size() - 1)), "R2 ack",
            {31'b0, inReady}, {31'b0, (outReady && (idx == expQ.size() - 1))});
        if (outReady) begin
          idx++;
          if (idx == expQ.size()) done = 1;
        end
      end
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] pw;
    // reset state: pending pair shows its first half (R2)
    inValid = 1'b1;
    pw = {1'b1, mkHalf(4, 2, 0, 5), 1'b0, mkHalf(6, 0, 0, 1)};
    inWord = pw;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(outWord == refHalf(pw[30:16]), "R2 reset first half", outWord, refHalf(pw[30:16]));
    inValid = 1'b0;
    @(negedge clk); #1;
    chk(outValid == 1'b0, "R1 idle", {31'b0, outValid}, 32'd0);
    rstN = 1'b1;

    // R1 plain words
    runWord({1'b0, 4'd3, 5'b00010, 3'b001, 1'b0, 18'h2ABCD}, "R1", 0);
    runWord({1'b0, 4'd9, 5'b01101, 3'b110, 1'b1, 4'd2, 14'h1F0F}, "R1", 0);
    // R7 simulator call and no-op
    runWord({1'b0, 4'd0, 5'b11110, 3'b000, 1'b0, 18'h00001}, "R7 sim", 0);
    runWord({1'b0, 4'd0, 5'b11111, 3'b000, 1'b1, 18'h3FFFF}, "R7 noop", 0);
    // R3 ALU forms
    runWord({1'b1, mkHalf(1, 0, 0, 'h7F), 1'b0, mkHalf(2, 1, 1, (5 << 3) | 4)}, "R3 sub/and", 0);
    runWord({1'b1, mkHalf(15, 2, 0, 'h3F), 1'b0, mkHalf(0, 3, 1, (11 << 3) | 3)}, "R3 add/cmp", 0);
    runWord({1'b1, mkHalf(7, 2, 0, 'h40), 1'b0, mkHalf(8, 0, 1, (0 << 3) | 7)}, "R3 extremes", 0);
    // R4 loads and stores
    runWord({1'b1, mkHalf(3, 4, 0, 'h40), 1'b0, mkHalf(4, 5, 0, 'h3F)}, "R4 sp base", 0);
    runWord({1'b1, mkHalf(5, 4, 1, (2 << 3) | 3), 1'b0, mkHalf(6, 5, 1, (14 << 3) | 4)}, "R4 reg base", 0);
    // R5 load immediate
    runWord({1'b1, mkHalf(10, 6, 1, 0), 1'b0, mkHalf(11, 6, 0, 'h7F)}, "R5 ldi", 0);
    runWord({1'b1, mkHalf(12, 6, 1, 'h7F), 1'b0, mkHalf(13, 6, 0, 0)}, "R5 ldi", 0);
    // R6 move
    runWord({1'b1, mkHalf(1, 7, 1, (7 << 3) | 0), 1'b0, mkHalf(2, 7, 0, (9 << 3) | 7)}, "R6 mov", 0);
    runWord({1'b1, mkHalf(3, 7, 1, (15 << 3) | 7), 1'b0, mkHalf(4, 7, 0, 0)}, "R6 mov", 0);
    // R2 spare bit 15 set has no effect
    runWord({1'b1, mkHalf(9, 2, 0, 'h11), 1'b1, mkHalf(10, 4, 0, 'h22)}, "R2 spare bit", 0);
    // R8 flush after first half, then a new pair starts at its first half
    runWord({1'b1, mkHalf(1, 2, 0, 1), 1'b0, mkHalf(2, 2, 0, 2)}, "R8 pre-flush", 1);
    runWord({1'b1, mkHalf(5, 1, 0, 'h15), 1'b0, mkHalf(6, 3, 0, 'h2A)}, "R8 after flush", 0);

    @(negedge clk);
    inValid = 1'b0;
    flush = 1'b0;
    #1;
    chk(outValid == 1'b0, "R1 idle end", {31'b0, outValid}, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule